// File: doc/BRIEF.md
# Cache Store Write-Policy Controller

This block takes one store at a time into a set-associative cache and decides what the store does to the cache and to memory. The store arrives with its address, up to eight bytes of data, a size code and the outcome of a tag lookup done elsewhere: hit or miss, the chosen way, whether a way may be used on a miss, and the state of the victim line in that way. Two configuration inputs select whether the cache is enabled at all and whether it runs copy-back or write-through.

Depending on that outcome, the controller writes the victim line back, fills a line, merges the store bytes into the data RAM, updates the line state word and the per-set recency order, and writes the store straight to memory. Memory is a request/grant port with a done pulse for line transfers. A recency query port returns the least recently used way of any set, so a lookup unit can pick its victim from it.

Top module: `store_policy_ctrl`

## Requirements
- R1: A store that is accepted while the cache is disabled, or whose address is at or above NC_BASE, produces exactly one memory request with op code 0 (word write) and no data RAM write, no line state write and no change to the recency order.
- R2: A hit in copy-back mode writes the store bytes into the hit way of the addressed set, writes the line state with valid=1, dirty=1 and the address tag, and makes no memory request.
- R3: A hit in write-through mode merges the bytes into the line like R2, writes the line state with dirty=0, and then issues one word write (op 0) to memory.
- R4: A copy-back miss with a usable way and a victim that is not both valid and dirty issues one line fill (op 1) at the line-aligned address; the merge follows the fill's done pulse and writes the line state with valid=1, dirty=1 and the new tag.
- R5: A copy-back miss whose victim is valid and dirty first issues a line write-back (op 2) at the address rebuilt from the victim tag and the set index with a zero offset, waits for its done pulse, then performs R4.
- R6: A miss in copy-back mode with no usable way (all locked) issues one word write only, with no fill and no data RAM or line state write.
- R7: A miss in write-through mode never allocates: it issues one word write only, with no fill.
- R8: st_busy rises in the cycle after a store is accepted and stays high until the whole sequence ends; a store presented while st_busy is high is ignored; an ungranted memory request holds its op and address.
- R9: The size code st_len selects 1, 2, 4 or 8 bytes (codes 0 to 3); the word write enable mem_be has those bits set starting at byte address bits [2:0], mem_addr is the store address with bits [2:0] cleared, mem_wdata carries the data shifted up by eight times those bits, and dw_be/dw_data place the same bytes at the byte offset within the line.
- R10: Each set keeps one age per way, equal to the way index after reset; a merge gives the touched way age 0 and ages by one the ways that were younger than it, and vq_way returns the way of the queried set whose age is the highest (WAYS-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cache_en | input | 1 | Cache enabled |
| cfg_copy_back | input | 1 | 1 = copy-back, 0 = write-through |
| st_valid | input | 1 | Store presented; taken when st_busy is low |
| st_addr | input | AW | Store byte address |
| st_data | input | WORD_BYTES*8 | Store data, low bytes first |
| st_len | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| st_hit | input | 1 | Lookup hit |
| st_way | input | log2(WAYS) | Hit way, or way to allocate on a miss |
| st_way_ok | input | 1 | A way is usable on a miss (not all locked) |
| st_vict_valid | input | 1 | Victim line valid |
| st_vict_dirty | input | 1 | Victim line dirty |
| st_vict_tag | input | TAGW | Victim line tag |
| st_busy | output | 1 | Controller occupied |
| mem_req | output | 1 | Memory request |
| mem_op | output | 2 | 0 word write, 1 line fill, 2 line write-back |
| mem_addr | output | AW | Request address |
| mem_wdata | output | WORD_BYTES*8 | Word write data |
| mem_be | output | WORD_BYTES | Word write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_done | input | 1 | Line fill or write-back finished |
| dw_we | output | 1 | Data RAM byte write |
| dw_set | output | SETW | Data RAM set |
| dw_way | output | log2(WAYS) | Data RAM way |
| dw_be | output | LINE_BYTES | Byte enables within the line |
| dw_data | output | LINE_BYTES*8 | Line-wide write data |
| ln_we | output | 1 | Line state write |
| ln_set | output | SETW | Line state set |
| ln_way | output | log2(WAYS) | Line state way |
| ln_tag | output | TAGW | Tag to store |
| ln_valid | output | 1 | Valid bit to store |
| ln_dirty | output | 1 | Dirty bit to store |
| vq_set | input | SETW | Recency query set |
| vq_way | output | log2(WAYS) | Least recently used way of vq_set |

## Verification
The assertions take for granted that a presented store never runs past the end of its eight-byte word, that the lookup fields are valid in the cycle st_valid is high, and that mem_done pulses only while a fill or write-back is outstanding after its grant. The bench keeps to this by choosing offset and size pairs that stay inside one word, driving all lookup fields together with st_valid, and raising mem_done from a memory model only a fixed number of cycles after it grants a line request. Grants are held back one cycle on every request so that the hold rule on ungranted requests is exercised each time.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WB,
    S_WBW,
    S_FILL,
    S_FILLW,
    S_MERGE,
    S_WT
  } spc_state_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_FILL  = 2'd1,
    OP_WBACK = 2'd2
  } spc_op_e;

endpackage

// File: rtl/spc_lane_mask.sv
module spc_lane_mask #(
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         chk_en,
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [1:0]                   len,
  input  logic [WORD_BYTES*8-1:0]      data,
  output logic [WORD_BYTES-1:0]        word_be,
  output logic [WORD_BYTES*8-1:0]      word_data,
  output logic [LINE_BYTES-1:0]        line_be,
  output logic [LINE_BYTES*8-1:0]      line_data
);
  localparam int OFFW  = $clog2(LINE_BYTES);
  localparam int WOFF  = $clog2(WORD_BYTES);
  localparam int WIDXW = OFFW - WOFF;
  localparam int CW    = WOFF + 2;

  logic [WOFF-1:0]  lo;
  logic [WIDXW-1:0] widx;
  logic [CW-1:0]    lo_c;
  logic [CW-1:0]    nb_c;

  assign lo   = off[WOFF-1:0];
  assign widx = off[OFFW-1:WOFF];
  assign lo_c = CW'(lo);
  assign nb_c = CW'(1) << len;

  assign word_data = data << {lo, 3'b000};

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_wbyte
    assign word_be[b] = (CW'(b) >= lo_c) && (CW'(b) < lo_c + nb_c);
  end

  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lbyte
    assign line_be[j]          = (widx == WIDXW'(j / WORD_BYTES)) && word_be[j % WORD_BYTES];
    assign line_data[j*8 +: 8] = word_data[(j % WORD_BYTES)*8 +: 8];
  end

  // R9
  be_count_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> ($countones(word_be) == int'(nb_c)));

  // R9
  line_count_chk: assert property (@(posedge clk) disable iff (rst)
    chk_en |-> ($countones(line_be) == $countones(word_be)));

endmodule

// File: rtl/spc_age_lru.sv
module spc_age_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_en,
  input  logic [$clog2(SETS)-1:0] upd_set,
  input  logic [$clog2(WAYS)-1:0] upd_way,
  input  logic [$clog2(SETS)-1:0] q_set,
  output logic [$clog2(WAYS)-1:0] q_way
);
  localparam int AGEW = $clog2(WAYS);

  logic [AGEW-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGEW'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGEW'(w) == upd_way)
          age_q[upd_set][w] <= '0;
        else if (age_q[upd_set][w] < age_q[upd_set][upd_way])
          age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    q_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[q_set][w] == AGEW'(WAYS-1))
        q_way = AGEW'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0] old_v;
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign old_v[w] = (age_q[s][w] == AGEW'(WAYS-1));
    end
    // R10
    lru_perm_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(old_v) == 1);
  end

  // R10
  lru_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (age_q[$past(upd_set)][$past(upd_way)] == '0));

endmodule

// File: rtl/store_policy_ctrl.sv
module store_policy_ctrl #(
  parameter int          AW         = 32,
  parameter int          WORD_BYTES = 8,
  parameter int          LINE_BYTES = 32,
  parameter int          SETS       = 16,
  parameter int          WAYS       = 4,
  parameter logic [31:0] NC_BASE    = 32'hF000_0000,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int SETW = $clog2(SETS),
  localparam int WAYW = $clog2(WAYS),
  localparam int TAGW = AW - OFFW - SETW,
  localparam int DW   = WORD_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_cache_en,
  input  logic                    cfg_copy_back,
  input  logic                    st_valid,
  input  logic [AW-1:0]           st_addr,
  input  logic [DW-1:0]           st_data,
  input  logic [1:0]              st_len,
  input  logic                    st_hit,
  input  logic [WAYW-1:0]         st_way,
  input  logic                    st_way_ok,
  input  logic                    st_vict_valid,
  input  logic                    st_vict_dirty,
  input  logic [TAGW-1:0]         st_vict_tag,
  output logic                    st_busy,
  output logic                    mem_req,
  output logic [1:0]              mem_op,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  output logic [WORD_BYTES-1:0]   mem_be,
  input  logic                    mem_gnt,
  input  logic                    mem_done,
  output logic                    dw_we,
  output logic [SETW-1:0]         dw_set,
  output logic [WAYW-1:0]         dw_way,
  output logic [LINE_BYTES-1:0]   dw_be,
  output logic [LINE_BYTES*8-1:0] dw_data,
  output logic                    ln_we,
  output logic [SETW-1:0]         ln_set,
  output logic [WAYW-1:0]         ln_way,
  output logic [TAGW-1:0]         ln_tag,
  output logic                    ln_valid,
  output logic                    ln_dirty,
  input  logic [SETW-1:0]         vq_set,
  output logic [WAYW-1:0]         vq_way
);
  import spc_pkg::*;
  localparam int WOFF = $clog2(WORD_BYTES);

  spc_state_e      st_q;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   d_q;
  logic [1:0]      l_q;
  logic [WAYW-1:0] way_q;
  logic [TAGW-1:0] vtag_q;
  logic            cb_q;

  logic            take;
  logic            bypass;
  logic [SETW-1:0] set_q;
  logic [TAGW-1:0] tag_q;
  logic [WORD_BYTES-1:0] word_be;

  assign take   = st_valid && (st_q == S_IDLE);
  assign bypass = !cfg_cache_en || (st_addr >= AW'(NC_BASE));
  assign set_q  = a_q[OFFW +: SETW];
  assign tag_q  = a_q[AW-1 -: TAGW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      a_q    <= '0;
      d_q    <= '0;
      l_q    <= '0;
      way_q  <= '0;
      vtag_q <= '0;
      cb_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (take) begin
          a_q    <= st_addr;
          d_q    <= st_data;
          l_q    <= st_len;
          way_q  <= st_way;
          vtag_q <= st_vict_tag;
          cb_q   <= cfg_copy_back;
          if (bypass)
            st_q <= S_WT;
          else if (st_hit)
            st_q <= S_MERGE;
          else if (st_way_ok && cfg_copy_back)
            st_q <= (st_vict_valid && st_vict_dirty) ? S_WB : S_FILL;
          else
            st_q <= S_WT;
        end
        S_WB:    if (mem_gnt)  st_q <= S_WBW;
        S_WBW:   if (mem_done) st_q <= S_FILL;
        S_FILL:  if (mem_gnt)  st_q <= S_FILLW;
        S_FILLW: if (mem_done) st_q <= S_MERGE;
        S_MERGE: st_q <= cb_q ? S_IDLE : S_WT;
        S_WT:    if (mem_gnt)  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  spc_lane_mask #(
    .WORD_BYTES (WORD_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) lane_i (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (st_q != S_IDLE),
    .off       (a_q[OFFW-1:0]),
    .len       (l_q),
    .data      (d_q),
    .word_be   (word_be),
    .word_data (mem_wdata),
    .line_be   (dw_be),
    .line_data (dw_data)
  );

  spc_age_lru #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) lru_i (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (st_q == S_MERGE),
    .upd_set (set_q),
    .upd_way (way_q),
    .q_set   (vq_set),
    .q_way   (vq_way)
  );

  always_comb begin
    mem_req  = (st_q == S_WB) || (st_q == S_FILL) || (st_q == S_WT);
    mem_op   = OP_WRITE;
    mem_addr = {a_q[AW-1:WOFF], {WOFF{1'b0}}};
    mem_be   = '0;
    case (st_q)
      S_WB: begin
        mem_op   = OP_WBACK;
        mem_addr = {vtag_q, set_q, {OFFW{1'b0}}};
      end
      S_FILL: begin
        mem_op   = OP_FILL;
        mem_addr = {a_q[AW-1:OFFW], {OFFW{1'b0}}};
      end
      S_WT: mem_be = word_be;
      default: ;
    endcase
  end

  assign st_busy  = (st_q != S_IDLE);
  assign dw_we    = (st_q == S_MERGE);
  assign dw_set   = set_q;
  assign dw_way   = way_q;
  assign ln_we    = (st_q == S_MERGE);
  assign ln_set   = set_q;
  assign ln_way   = way_q;
  assign ln_tag   = tag_q;
  assign ln_valid = 1'b1;
  assign ln_dirty = cb_q;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_op) && $stable(mem_addr)));

  // R1
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_busy && bypass) |=> (!dw_we && !ln_we && mem_req && mem_op == OP_WRITE));

  // R4
  fill_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_FILLW && mem_done) |=> (dw_we && ln_we && ln_valid && ln_dirty));

  // R5
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WBW && mem_done) |=> (mem_req && mem_op == OP_FILL));

  // R9
  word_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_busy) |-> (int'(st_addr[WOFF-1:0]) + (1 << st_len) <= WORD_BYTES));

endmodule

// File: tb/store_policy_ctrl_tb_top.sv
`timescale 1ns/1ps
module store_policy_ctrl_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_cache_en = 1'b1;
  logic         cfg_copy_back = 1'b1;
  logic         st_valid = 1'b0;
  logic [31:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic [1:0]   st_len = '0;
  logic         st_hit = 1'b0;
  logic [1:0]   st_way = '0;
  logic         st_way_ok = 1'b0;
  logic         st_vict_valid = 1'b0;
  logic         st_vict_dirty = 1'b0;
  logic [22:0]  st_vict_tag = '0;
  logic         st_busy;
  logic         mem_req;
  logic [1:0]   mem_op;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic [7:0]   mem_be;
  logic         mem_gnt = 1'b0;
  logic         mem_done = 1'b0;
  logic         dw_we;
  logic [3:0]   dw_set;
  logic [1:0]   dw_way;
  logic [31:0]  dw_be;
  logic [255:0] dw_data;
  logic         ln_we;
  logic [3:0]   ln_set;
  logic [1:0]   ln_way;
  logic [22:0]  ln_tag;
  logic         ln_valid;
  logic         ln_dirty;
  logic [3:0]   vq_set = '0;
  logic [1:0]   vq_way;

  int total = 0;
  int bad   = 0;

  store_policy_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_cache_en(cfg_cache_en), .cfg_copy_back(cfg_copy_back),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_len(st_len),
    .st_hit(st_hit), .st_way(st_way), .st_way_ok(st_way_ok),
    .st_vict_valid(st_vict_valid), .st_vict_dirty(st_vict_dirty), .st_vict_tag(st_vict_tag),
    .st_busy(st_busy), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_done(mem_done),
    .dw_we(dw_we), .dw_set(dw_set), .dw_way(dw_way), .dw_be(dw_be), .dw_data(dw_data),
    .ln_we(ln_we), .ln_set(ln_set), .ln_way(ln_way), .ln_tag(ln_tag),
    .ln_valid(ln_valid), .ln_dirty(ln_dirty), .vq_set(vq_set), .vq_way(vq_way)
  );

  always #2 clk = ~clk;

  // event log, sampled at the active edge from values settled before it
  int          n_mem, n_dw, n_ln;
  logic [1:0]  lg_op   [4];
  logic [31:0] lg_addr [4];
  logic [7:0]  lg_be   [4];
  logic [63:0] lg_data [4];
  logic [3:0]  s_dw_set;
  logic [1:0]  s_dw_way;
  logic [31:0] s_dw_be;
  logic [255:0] s_dw_data;
  logic [22:0] s_ln_tag;
  logic        s_ln_valid, s_ln_dirty;

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_req && mem_gnt) begin
        if (n_mem < 4) begin
          lg_op[n_mem]   = mem_op;
          lg_addr[n_mem] = mem_addr;
          lg_be[n_mem]   = mem_be;
          lg_data[n_mem] = mem_wdata;
        end
        n_mem++;
      end
      if (dw_we) begin
        n_dw++;
        s_dw_set = dw_set; s_dw_way = dw_way; s_dw_be = dw_be; s_dw_data = dw_data;
      end
      if (ln_we) begin
        n_ln++;
        s_ln_tag = ln_tag; s_ln_valid = ln_valid; s_ln_dirty = ln_dirty;
      end
    end
  end

  // memory model: every request waits one cycle for its grant, line transfers finish later
  initial begin
    bit seen = 0;
    int done_cnt = 0;
    forever begin
      @(negedge clk);
      mem_done = 1'b0;
      if (done_cnt > 0) begin
        done_cnt--;
        if (done_cnt == 0) mem_done = 1'b1;
      end
      mem_gnt = mem_req && seen;
      seen = mem_req && !mem_gnt;
      if (mem_gnt && mem_op != 2'd0) done_cnt = 3;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [63:0] d, input logic [1:0] len,
                       input logic hit, input logic [1:0] way, input logic wok,
                       input logic vv, input logic vd, input logic [22:0] vt, input bit poke);
    int guard = 0;
    @(negedge clk);
    n_mem = 0; n_dw = 0; n_ln = 0;
    st_addr = a; st_data = d; st_len = len; st_hit = hit; st_way = way;
    st_way_ok = wok; st_vict_valid = vv; st_vict_dirty = vd; st_vict_tag = vt;
    st_valid = 1'b1;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_busy == 1'b1, "R8 busy after accept", 256'(st_busy), 256'(1));
    if (poke) begin
      st_addr = 32'hF000_0100; st_len = 2'd0; st_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(st_busy == 1'b1, "R8 busy through sequence", 256'(st_busy), 256'(1));
      st_valid = 1'b0;
    end
    while (st_busy && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic check_lru(input logic [3:0] s, input logic [1:0] exp, input string req);
    @(negedge clk);
    vq_set = s;
    #1;
    chk(vq_way == exp, req, 256'(vq_way), 256'(exp));
  endtask

  task automatic t_reset;
    chk(st_busy == 1'b0, "R8 idle after reset", 256'(st_busy), 256'(0));
    chk(mem_req == 1'b0, "R8 no request after reset", 256'(mem_req), 256'(0));
    check_lru(4'd1, 2'd3, "R10 reset oldest way");
  endtask

  task automatic t_uncached;
    issue(32'hF000_0013, 64'hBEEF, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, '0, 0);
    chk(n_mem == 1, "R1 one request", 256'(n_mem), 256'(1));
    chk(lg_op[0] == 2'd0, "R1 op write", 256'(lg_op[0]), 256'(0));
    chk(lg_addr[0] == 32'hF000_0010, "R9 word address", 256'(lg_addr[0]), 256'(32'hF000_0010));
    chk(lg_be[0] == 8'h18, "R9 byte enables", 256'(lg_be[0]), 256'(8'h18));
    chk(lg_data[0] == 64'h0000_00BE_EF00_0000, "R9 shifted data", 256'(lg_data[0]), 256'(64'h0000_00BE_EF00_0000));
    chk(n_dw == 0 && n_ln == 0, "R1 cache untouched", 256'(n_dw + n_ln), 256'(0));
    check_lru(4'd0, 2'd3, "R1 recency untouched");
  endtask

  task automatic t_disabled;
    cfg_cache_en = 1'b0;
    issue(32'h0000_0405, 64'h77, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, '0, 0);
    cfg_cache_en = 1'b1;
    chk(n_mem == 1 && lg_op[0] == 2'd0, "R1 disabled write", 256'(n_mem), 256'(1));
    chk(lg_be[0] == 8'h20, "R9 single byte enable", 256'(lg_be[0]), 256'(8'h20));
    chk(lg_data[0] == 64'h0000_7700_0000_0000, "R9 single byte data", 256'(lg_data[0]), 256'(64'h0000_7700_0000_0000));
    chk(n_dw == 0 && n_ln == 0, "R1 disabled no merge", 256'(n_dw + n_ln), 256'(0));
  endtask

  task automatic t_hit_cb;
    cfg_copy_back = 1'b1;
    issue(32'h0000_1234, 64'hCAFE_F00D, 2'd2, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, '0, 0);
    chk(n_mem == 0, "R2 no memory traffic", 256'(n_mem), 256'(0));
    chk(n_dw == 1 && s_dw_set == 4'd1 && s_dw_way == 2'd3, "R2 merge target",
        256'({s_dw_set, s_dw_way}), 256'({4'd1, 2'd3}));
    chk(s_dw_be == 32'h00F0_0000, "R9 line enables", 256'(s_dw_be), 256'(32'h00F0_0000));
    chk(s_dw_data[191:160] == 32'hCAFE_F00D, "R9 line data", 256'(s_dw_data[191:160]), 256'(32'hCAFE_F00D));
    chk(n_ln == 1 && s_ln_dirty && s_ln_valid && s_ln_tag == 23'h9, "R2 line state",
        256'({s_ln_tag, s_ln_valid, s_ln_dirty}), 256'({23'h9, 1'b1, 1'b1}));
    check_lru(4'd1, 2'd2, "R10 after touching way 3");
  endtask

  task automatic t_hit_wt;
    cfg_copy_back = 1'b0;
    issue(32'h0000_1228, 64'h1122_3344_5566_7788, 2'd3, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, '0, 0);
    cfg_copy_back = 1'b1;
    chk(n_dw == 1 && s_dw_be == 32'h0000_FF00, "R3 merge enables", 256'(s_dw_be), 256'(32'h0000_FF00));
    chk(s_dw_data[127:64] == 64'h1122_3344_5566_7788, "R3 merge data", 256'(s_dw_data[127:64]), 256'(64'h1122_3344_5566_7788));
    chk(n_ln == 1 && !s_ln_dirty && s_ln_valid, "R3 dirty cleared", 256'(s_ln_dirty), 256'(0));
    chk(n_mem == 1 && lg_op[0] == 2'd0 && lg_addr[0] == 32'h0000_1228, "R3 memory write",
        256'(lg_addr[0]), 256'(32'h0000_1228));
    chk(lg_be[0] == 8'hFF && lg_data[0] == 64'h1122_3344_5566_7788, "R3 full word",
        256'(lg_be[0]), 256'(8'hFF));
    check_lru(4'd1, 2'd1, "R10 after touching way 2");
  endtask

  task automatic t_miss_clean;
    issue(32'h0000_2046, 64'h5A, 2'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 23'h3, 0);
    chk(n_mem == 1 && lg_op[0] == 2'd1, "R4 single fill", 256'({n_mem[3:0], lg_op[0]}), 256'({4'd1, 2'd1}));
    chk(lg_addr[0] == 32'h0000_2040, "R4 fill aligned", 256'(lg_addr[0]), 256'(32'h0000_2040));
    chk(n_dw == 1 && s_dw_set == 4'd2 && s_dw_way == 2'd1 && s_dw_be == 32'h40, "R4 merge after fill",
        256'(s_dw_be), 256'(32'h40));
    chk(s_dw_data[55:48] == 8'h5A, "R4 merged byte", 256'(s_dw_data[55:48]), 256'(8'h5A));
    chk(n_ln == 1 && s_ln_tag == 23'h10 && s_ln_valid && s_ln_dirty, "R4 new tag valid dirty",
        256'({s_ln_tag, s_ln_valid, s_ln_dirty}), 256'({23'h10, 1'b1, 1'b1}));
  endtask

  task automatic t_miss_dirty;
    issue(32'h0000_3060, 64'hA5A5, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 23'h55, 1);
    chk(n_mem == 2, "R8 ignored store while busy", 256'(n_mem), 256'(2));
    chk(lg_op[0] == 2'd2 && lg_addr[0] == 32'h0000_AA60, "R5 write-back first",
        256'({lg_op[0], lg_addr[0]}), 256'({2'd2, 32'h0000_AA60}));
    chk(lg_op[1] == 2'd1 && lg_addr[1] == 32'h0000_3060, "R5 fill second",
        256'({lg_op[1], lg_addr[1]}), 256'({2'd1, 32'h0000_3060}));
    chk(n_dw == 1 && s_dw_set == 4'd3 && s_dw_way == 2'd0, "R5 merge into victim way",
        256'({s_dw_set, s_dw_way}), 256'({4'd3, 2'd0}));
  endtask

  task automatic t_locked;
    issue(32'h0000_5010, 64'h1234, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 23'h7, 0);
    chk(n_mem == 1 && lg_op[0] == 2'd0 && lg_addr[0] == 32'h0000_5010, "R6 write only",
        256'({n_mem[3:0], lg_op[0]}), 256'({4'd1, 2'd0}));
    chk(lg_be[0] == 8'h03 && lg_data[0] == 64'h1234, "R6 word content", 256'(lg_be[0]), 256'(8'h03));
    chk(n_dw == 0 && n_ln == 0, "R6 no allocation", 256'(n_dw + n_ln), 256'(0));
  endtask

  task automatic t_miss_wt;
    cfg_copy_back = 1'b0;
    issue(32'h0000_6004, 64'hDEAD_BEEF, 2'd2, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 23'h2, 0);
    cfg_copy_back = 1'b1;
    chk(n_mem == 1 && lg_op[0] == 2'd0 && lg_addr[0] == 32'h0000_6000, "R7 write no fill",
        256'({n_mem[3:0], lg_op[0]}), 256'({4'd1, 2'd0}));
    chk(lg_be[0] == 8'hF0 && lg_data[0] == 64'hDEAD_BEEF_0000_0000, "R7 upper half word",
        256'(lg_data[0]), 256'(64'hDEAD_BEEF_0000_0000));
    chk(n_dw == 0 && n_ln == 0, "R7 no allocation", 256'(n_dw + n_ln), 256'(0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_uncached();
    t_disabled();
    t_hit_cb();
    t_hit_wt();
    t_miss_clean();
    t_miss_dirty();
    t_locked();
    t_miss_wt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule